// File: doc/BRIEF.md
# Ethernet Transmit Frame Formatter

This block turns a stream of frame payload bytes into the byte sequence a MAC transmitter puts on the line. Payload arrives on a byte-wide valid/ready stream with a last marker. By default the block puts the preamble and start delimiter in front of the payload. It extends short frames to the 60-byte minimum and appends a CRC-32 frame check sequence. The result leaves as a registered byte stream with valid, start-of-frame and end-of-frame markers.

Four per-port control bits change the framing. One drops the preamble, one disables padding and one suppresses the check sequence. The fourth selects the interface mode, and the pad byte depends on it. The block also decides when a frame may begin. In half duplex it waits for carrier sense to clear. In full duplex it starts at once. Full duplex is in force when either a hardware pin or a software bit requests it. The control bits are captured when a frame starts and have no effect until that frame has ended.

Top module: `etx_formatter`

## Requirements
- R1: Unless `cfg_no_pre` is set, a frame begins with seven 0x55 bytes and then one 0xD5 byte. Only the first of these carries `m_sof`.
- R2: With `cfg_no_pre` set, the first output byte of a frame is the first payload byte, and it carries `m_sof`.
- R3: With `cfg_no_pad` clear, a frame with fewer than 60 payload bytes is extended with pad bytes to exactly 60 bytes, not counting the FCS. The pad bytes follow the payload and come before the FCS. A frame of 60 or more payload bytes is passed through unchanged.
- R4: A pad byte is 0x00 when `cfg_mii` is 0 (serial mode) and 0x55 when `cfg_mii` is 1 (MII mode).
- R5: With `cfg_no_pad` set, a short frame is sent without any pad bytes.
- R6: With `cfg_no_fcs` clear, the payload and pad bytes are followed by four FCS bytes, and the last of them carries `m_eof`. The FCS is a CRC-32 with polynomial 0x04C11DB7, preset to all ones and computed over the payload and pad bytes. It is complemented and sent least-significant byte first, so the payload "123456789" gives the bytes 0x26 0x39 0xF4 0xCB.
- R7: With `cfg_no_fcs` set, no FCS is sent, and the last payload or pad byte carries `m_eof`.
- R8: In half duplex, a frame does not start while `crs` is high: no output byte appears and `s_ready` stays low. The frame starts once `crs` falls.
- R9: Full duplex applies when `fd_pin` or `cfg_fd_sw` is 1. In full duplex a frame starts while `crs` is high.
- R10: The mode inputs are captured when a frame starts. Changing them during the frame does not alter that frame.
- R11: While `rst_n` is low, and after reset is released, `m_valid` and `s_ready` are 0 until a frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte valid |
| s_last | input | 1 | Marks the last payload byte of a frame |
| s_ready | output | 1 | Formatter accepts a payload byte this cycle |
| cfg_no_pre | input | 1 | Suppress preamble and start delimiter |
| cfg_no_pad | input | 1 | Disable padding of short frames |
| cfg_no_fcs | input | 1 | Suppress the frame check sequence |
| cfg_mii | input | 1 | Interface mode: 1 for MII (pad 0x55), 0 for serial (pad 0x00) |
| cfg_fd_sw | input | 1 | Software full-duplex request |
| fd_pin | input | 1 | Hardware full-duplex request |
| crs | input | 1 | Carrier sense |
| m_data | output | 8 | Transmit byte |
| m_valid | output | 1 | Transmit byte valid |
| m_sof | output | 1 | First byte of a frame |
| m_eof | output | 1 | Last byte of a frame |

## Verification
The assertions check four rules on every cycle:
- No frame starts in half duplex while carrier is present.
- The preamble and FCS states are never entered when the captured mode bits suppress them.
- A padded frame never reaches its check sequence short of 60 bytes.
- The captured mode does not change while a frame is in flight.

Only the bench scenarios can show that the output bytes are correct: the exact preamble, pad value, pad count and CRC bytes, and where the start and end markers fall. The same holds for the frame that waits on carrier and then starts once it clears.

// File: rtl/etx_pkg.sv
// Shared types, byte constants and the CRC-32 byte step of the transmit formatter.
package etx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_FCS
    } etx_state_e;

    typedef struct packed {
        logic no_pre;
        logic no_pad;
        logic no_fcs;
        logic mii;
    } etx_mode_t;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;
    localparam logic [7:0] PAD_MII  = 8'h55;
    localparam logic [7:0] PAD_SER  = 8'h00;
    localparam logic [31:0] CRC_REFL_POLY = 32'hEDB88320;

    // One byte of the reflected CRC-32 (LSB-first form of 0x04C11DB7).
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_REFL_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/etx_crc32.sv
// CRC-32 accumulator.
// Presets to all ones on init and folds in one byte per enabled cycle.
// Assumes init and en are never asserted together.
module etx_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  d,
    output logic [31:0] crc
);
    import etx_pkg::*;

    // Running remainder register.
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc <= '1;
        else if (en)        crc <= crc_step(crc, d);
    end
endmodule

// File: rtl/etx_start_gate.sv
// Start permission.
// Full duplex is the OR of the pin and the software bit. Half duplex defers to carrier sense.
// Assumes crs is already synchronised to clk.
module etx_start_gate (
    input  logic fd_pin,
    input  logic fd_sw,
    input  logic crs,
    output logic fd,
    output logic can_start
);
    // Duplex resolution and deferral decision.
    always_comb begin
        fd        = fd_pin | fd_sw;
        can_start = fd | ~crs;
    end
endmodule

// File: rtl/etx_mode_reg.sv
// Per-frame mode capture.
// Loads the control bits at frame start and holds them while the frame is busy.
// Assumes load is asserted only when the formatter is idle.
module etx_mode_reg (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               busy,
    input  etx_pkg::etx_mode_t d,
    output etx_pkg::etx_mode_t q
);
    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(q)); // R10
endmodule

// File: rtl/etx_formatter.sv
// Ethernet transmit frame formatter.
// Adds the preamble, pads short frames and appends the FCS around a payload byte stream.
// Assumes the downstream side accepts one byte every cycle.
// A payload gap while valid is low produces an output gap.
module etx_formatter #(
    parameter int MIN_LEN = 60,
    parameter int PRE_LEN = 7,
    parameter int FCS_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    input  logic       cfg_no_pre,
    input  logic       cfg_no_pad,
    input  logic       cfg_no_fcs,
    input  logic       cfg_mii,
    input  logic       cfg_fd_sw,
    input  logic       fd_pin,
    input  logic       crs,
    output logic [7:0] m_data,
    output logic       m_valid,
    output logic       m_sof,
    output logic       m_eof
);
    import etx_pkg::*;

    localparam int CNT_W = $clog2(MIN_LEN + 1);
    localparam int SUB_W = $clog2(PRE_LEN + FCS_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MIN  = CNT_W'(MIN_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_LEN - 1);
    localparam logic [SUB_W-1:0] SUB_SFD  = SUB_W'(PRE_LEN);
    localparam logic [SUB_W-1:0] SUB_FCS  = SUB_W'(FCS_LEN - 1);

    etx_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SUB_W-1:0] sub_q, sub_d;
    logic             fd, can_start, start;
    etx_mode_t        mode_in, mode_q;
    logic [31:0]      crc, fcs_word;
    logic             crc_en;
    logic [7:0]       crc_byte, pad_byte;
    logic [7:0]       od;
    logic             ov, osof, oeof;

    etx_start_gate u_gate (
        .fd_pin    (fd_pin),
        .fd_sw     (cfg_fd_sw),
        .crs       (crs),
        .fd        (fd),
        .can_start (can_start)
    );

    etx_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .busy  (st_q != ST_IDLE),
        .d     (mode_in),
        .q     (mode_q)
    );

    etx_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start),
        .en    (crc_en),
        .d     (crc_byte),
        .crc   (crc)
    );

    // Frame start qualification and the derived per-frame values.
    always_comb begin
        mode_in  = '{no_pre: cfg_no_pre, no_pad: cfg_no_pad, no_fcs: cfg_no_fcs, mii: cfg_mii};
        start    = (st_q == ST_IDLE) && s_valid && can_start;
        s_ready  = (st_q == ST_DATA);
        pad_byte = mode_q.mii ? PAD_MII : PAD_SER;
        fcs_word = ~crc;
    end

    // Next-state, counters and the byte to emit this cycle.
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        sub_d    = sub_q;
        ov       = 1'b0;
        od       = 8'h00;
        osof     = 1'b0;
        oeof     = 1'b0;
        crc_en   = 1'b0;
        crc_byte = 8'h00;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    cnt_d = '0;
                    sub_d = '0;
                    st_d  = cfg_no_pre ? ST_DATA : ST_PRE;
                end
            end
            ST_PRE: begin
                ov   = 1'b1;
                od   = (sub_q == SUB_SFD) ? SFD_BYTE : PRE_BYTE;
                osof = (sub_q == '0);
                if (sub_q == SUB_SFD) begin
                    st_d  = ST_DATA;
                    sub_d = '0;
                end else begin
                    sub_d = sub_q + 1'b1;
                end
            end
            ST_DATA: begin
                if (s_valid) begin
                    ov       = 1'b1;
                    od       = s_data;
                    osof     = mode_q.no_pre && (cnt_q == '0);
                    crc_en   = 1'b1;
                    crc_byte = s_data;
                    cnt_d    = (cnt_q == CNT_MIN) ? cnt_q : cnt_q + 1'b1;
                    if (s_last) begin
                        if (!mode_q.no_pad && (cnt_q < CNT_LAST)) begin
                            st_d = ST_PAD;
                        end else if (!mode_q.no_fcs) begin
                            st_d  = ST_FCS;
                            sub_d = '0;
                        end else begin
                            oeof = 1'b1;
                            st_d = ST_IDLE;
                        end
                    end
                end
            end
            ST_PAD: begin
                ov       = 1'b1;
                od       = pad_byte;
                crc_en   = 1'b1;
                crc_byte = pad_byte;
                cnt_d    = cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) begin
                    if (!mode_q.no_fcs) begin
                        st_d  = ST_FCS;
                        sub_d = '0;
                    end else begin
                        oeof = 1'b1;
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_FCS: begin
                ov = 1'b1;
                od = fcs_word[8*sub_q[1:0] +: 8];
                if (sub_q == SUB_FCS) begin
                    oeof = 1'b1;
                    st_d = ST_IDLE;
                end else begin
                    sub_d = sub_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, counters and registered output stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            sub_q   <= '0;
            m_data  <= 8'h00;
            m_valid <= 1'b0;
            m_sof   <= 1'b0;
            m_eof   <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            sub_q   <= sub_d;
            m_data  <= od;
            m_valid <= ov;
            m_sof   <= osof;
            m_eof   <= oeof;
        end
    end

    AST_HD_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (fd_pin || cfg_fd_sw || !crs)); // R8
    AST_NO_PRE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRE) |-> !mode_q.no_pre); // R2
    AST_NO_FCS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FCS) |-> !mode_q.no_fcs); // R7
    AST_PAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FCS && !mode_q.no_pad) |-> (cnt_q == CNT_MIN)); // R3
    AST_EOF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (m_eof || m_sof) |-> m_valid); // R6
endmodule

// File: tb/tb_etx_formatter.sv
module tb_etx_formatter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_valid = 1'b0, s_last = 1'b0;
    logic       s_ready;
    logic       cfg_no_pre = 0, cfg_no_pad = 0, cfg_no_fcs = 0, cfg_mii = 0, cfg_fd_sw = 0;
    logic       fd_pin = 0, crs = 0;
    logic [7:0] m_data;
    logic       m_valid, m_sof, m_eof;

    always #10 clk = ~clk;

    etx_formatter dut (
        .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
        .s_ready(s_ready), .cfg_no_pre(cfg_no_pre), .cfg_no_pad(cfg_no_pad),
        .cfg_no_fcs(cfg_no_fcs), .cfg_mii(cfg_mii), .cfg_fd_sw(cfg_fd_sw), .fd_pin(fd_pin),
        .crs(crs), .m_data(m_data), .m_valid(m_valid), .m_sof(m_sof), .m_eof(m_eof)
    );

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] txbuf [0:255];
    logic [7:0] cap_d [0:127];
    logic       cap_s [0:127];
    logic       cap_e [0:127];
    int         ncap = 0;
    logic       got_eof = 0;
    logic [7:0] exp_d [0:127];
    int         exp_n;

    // {len[7:0], no_pre, no_pad, no_fcs, mii}
    localparam logic [11:0] VEC [9] = '{
        {8'd10, 4'b0000}, {8'd10, 4'b0001}, {8'd60, 4'b0000}, {8'd75, 4'b0001},
        {8'd59, 4'b1001}, {8'd20, 4'b0100}, {8'd5,  4'b0011}, {8'd1,  4'b1110},
        {8'd61, 4'b1100}
    };

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, expv, expv);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_valid && ncap < 128) begin
            cap_d[ncap] = m_data;
            cap_s[ncap] = m_sof;
            cap_e[ncap] = m_eof;
            ncap++;
            if (m_eof) got_eof = 1;
        end
    end

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else r = r >> 1;
        end
        return r;
    endfunction

    task automatic build_exp(input int len, input bit npre, input bit npad, input bit nfcs, input bit mii);
        logic [31:0] c = 32'hFFFFFFFF;
        int body = len;
        exp_n = 0;
        if (!npre) begin
            for (int i = 0; i < 7; i++) exp_d[exp_n++] = 8'h55;
            exp_d[exp_n++] = 8'hD5;
        end
        for (int i = 0; i < len; i++) begin
            exp_d[exp_n++] = txbuf[i];
            c = ref_crc(c, txbuf[i]);
        end
        if (!npad) while (body < 60) begin
            exp_d[exp_n++] = mii ? 8'h55 : 8'h00;
            c = ref_crc(c, mii ? 8'h55 : 8'h00);
            body++;
        end
        c = ~c;
        if (!nfcs) for (int i = 0; i < 4; i++) exp_d[exp_n++] = c[8*i +: 8];
    endtask

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < len; i++) txbuf[i] = 8'((i * 37 + seed) & 8'hFF);
    endtask

    task automatic clear_cap();
        ncap = 0;
        got_eof = 0;
    endtask

    task automatic send_frame(input int len);
        int  idx = 0;
        bit  hs;
        @(negedge clk);
        s_valid = 1; s_data = txbuf[0]; s_last = (len == 1);
        while (idx < len) begin
            hs = s_ready;
            @(negedge clk);
            if (hs) begin
                idx++;
                if (idx < len) begin
                    s_data = txbuf[idx]; s_last = (idx == len - 1);
                end else begin
                    s_valid = 0; s_last = 0;
                end
            end
        end
    endtask

    task automatic check_frame(input int len, input bit npre, input bit npad, input bit nfcs,
                               input bit mii, input string tag);
        int  t = 0;
        int  bad = -1;
        bit  flags_ok = 1;
        while (!got_eof && t < 400) begin
            @(negedge clk);
            t++;
        end
        build_exp(len, npre, npad, nfcs, mii);
        check(ncap == exp_n, tag, "byte count", ncap, exp_n);
        for (int i = 0; i < exp_n && i < ncap; i++)
            if (bad < 0 && cap_d[i] !== exp_d[i]) bad = i;
        check(bad < 0, tag, $sformatf("byte %0d", bad), (bad < 0) ? 0 : cap_d[bad],
              (bad < 0) ? 0 : exp_d[bad]);
        for (int i = 0; i < ncap; i++) begin
            if (cap_s[i] !== (i == 0)) flags_ok = 0;
            if (cap_e[i] !== (i == ncap - 1)) flags_ok = 0;
        end
        check(flags_ok, tag, "sof/eof placement", flags_ok, 1);
    endtask

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        check(m_valid == 0, "R11", "m_valid in reset", m_valid, 0);
        check(s_ready == 0, "R11", "s_ready in reset", s_ready, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(m_valid == 0 && s_ready == 0, "R11", "idle after reset", {m_valid, s_ready}, 0);

        // Table of framing vectors.
        for (int v = 0; v < 9; v++) begin
            int len = int'(VEC[v][11:4]);
            {cfg_no_pre, cfg_no_pad, cfg_no_fcs, cfg_mii} = VEC[v][3:0];
            tag = $sformatf("%s %s %s%s vec%0d", cfg_no_pre ? "R2" : "R1",
                            cfg_no_pad ? "R5" : "R3", cfg_no_fcs ? "R7" : "R6",
                            (!cfg_no_pad && len < 60) ? " R4" : "", v);
            fill(len, v * 11 + 3);
            clear_cap();
            send_frame(len);
            check_frame(len, cfg_no_pre, cfg_no_pad, cfg_no_fcs, cfg_mii, tag);
        end

        // R6: known CRC value.
        {cfg_no_pre, cfg_no_pad, cfg_no_fcs, cfg_mii} = 4'b1100;
        for (int i = 0; i < 9; i++) txbuf[i] = 8'(8'h31 + i);
        clear_cap();
        send_frame(9);
        check_frame(9, 1, 1, 0, 0, "R6");
        check({cap_d[12], cap_d[11], cap_d[10], cap_d[9]} == 32'hCBF43926, "R6", "check value",
              {cap_d[12], cap_d[11], cap_d[10], cap_d[9]}, 32'hCBF43926);

        // R8: half duplex deferral.
        {cfg_no_pre, cfg_no_pad, cfg_no_fcs, cfg_mii} = 4'b0000;
        fill(12, 77);
        clear_cap();
        crs = 1;
        fork
            send_frame(12);
            begin
                repeat (20) @(negedge clk);
                check(ncap == 0 && s_ready == 0, "R8", "output while carrier", ncap, 0);
                crs = 0;
            end
        join
        check_frame(12, 0, 0, 0, 0, "R8");

        // R9: full duplex via pin, then via software bit.
        crs = 1; fd_pin = 1;
        fill(14, 5);
        clear_cap();
        send_frame(14);
        check_frame(14, 0, 0, 0, 0, "R9 pin");
        fd_pin = 0; cfg_fd_sw = 1;
        fill(30, 9);
        clear_cap();
        send_frame(30);
        check_frame(30, 0, 0, 0, 0, "R9 sw");
        cfg_fd_sw = 0; crs = 0;

        // R10: mode changes mid-frame are ignored.
        fill(8, 21);
        clear_cap();
        fork
            send_frame(8);
            begin
                repeat (4) @(negedge clk);
                cfg_mii = 1; cfg_no_fcs = 1; cfg_no_pre = 1; cfg_no_pad = 1;
            end
        join
        check_frame(8, 0, 0, 0, 0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule